// File: doc/BRIEF.md
# Commit Token Arbiter with Signature Conflict Abort

This block puts the commits of lazily checked transactions, running on several cores, into one global order. A core whose transaction has finished raises its commit request. The block holds a single commit token and grants it to one requesting core at a time. While a core holds the token, the block broadcasts that core's write-set signature to the other cores. It then compares the broadcast against the read-set signature of every other core. A core whose read-set shares at least one set bit with the broadcast is aborted. The committer is never delayed and is never aborted.

Read-sets and write-sets arrive as fixed-width hashed signatures. Two different addresses can hash to the same bit, so an abort can be a false conflict. The block accepts that cost in exchange for a compare of fixed size. A token tenure is always two cycles: one broadcast cycle and one evaluation cycle. Arbitration for the next tenure takes place during the evaluation cycle, so a new commit can begin every two cycles.

The request follows a valid/ready rule. `commit_req[i]` acts as valid and `grant[i]` acts as ready. A core keeps its request high until it sees its grant. It may drop the request when it sees its abort. A request that is still high while the same core's abort is asserted does not count in that cycle's arbitration. Nothing stalls the committer: the broadcast and the aborts carry no back-pressure.

Top module: `commit_token_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grant`, `abort` and `bcast_valid` are all zero and `bcast_sig` is zero.
- R2: `grant` has at most one bit set. A grant first appears in the cycle after an edge at which that core's request was high and the token was free or in its evaluation cycle.
- R3: Arbitration is round-robin. The search starts at the core after the last winner and wraps around. After reset, core 0 has the highest priority.
- R4: A tenure is exactly two cycles with the same `grant`. In the first cycle `bcast_valid` is 1 and `bcast_sig` is the winner's write signature, captured at the granting edge. In the second cycle `bcast_valid` is 0. When `bcast_valid` is 0, `bcast_sig` is zero.
- R5: In the evaluation cycle, `abort[i]` is 1 exactly when core i is not the committer and the bitwise AND of the broadcast signature with core i's read signature is nonzero. The read signature is the one sampled at the end of the broadcast cycle. A single shared bit is enough, so hash collisions also abort. Outside the evaluation cycle, `abort` is zero.
- R6: The committer's `abort` bit is never set, even when its own read signature overlaps its write signature.
- R7: A core that is aborted in an evaluation cycle is not granted at the end of that cycle, even if its request is still high.
- R8: If another eligible request is present during an evaluation cycle, the next tenure begins in the very next cycle with no idle gap. Otherwise the token goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_req | input | NCORE | Per-core commit request (valid) |
| wr_sig | input | NCORE*SIGW | Per-core write-set signatures; core i occupies bits [i*SIGW +: SIGW] |
| rd_sig | input | NCORE*SIGW | Per-core read-set signatures; same packing as `wr_sig` |
| grant | output | NCORE | One-hot commit token holder (ready) |
| bcast_valid | output | 1 | High in the broadcast cycle of a tenure |
| bcast_sig | output | SIGW | Broadcast write signature, zero when not valid |
| abort | output | NCORE | Per-core abort, driven in the evaluation cycle |

## Verification
A wrong owner or last-winner register shows up at the ports within two cycles. It appears as a grant out of rotation order, or as a broadcast signature that belongs to a different core. A stale abort mask appears in the evaluation cycle itself, as an abort on a core whose read signature does not overlap, or on the committer. One cycle later it can also show as an aborted core being granted. A wrong state register breaks the two-cycle tenure shape immediately: `bcast_valid` stays high or repeats, or an idle gap appears between back-to-back tenures.

// File: rtl/commit_tok_pkg.sv
package commit_tok_pkg;

  typedef enum logic [1:0] {
    TOK_IDLE  = 2'd0,
    TOK_BCAST = 2'd1,
    TOK_EVAL  = 2'd2
  } tok_state_e;

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Search starts one past the last winner and wraps around.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 1; k <= N; k++) begin
      if (!any && req[(int'(last) + k) % N]) begin
        any = 1'b1;
        idx = IW'((int'(last) + k) % N);
      end
    end
  end

endmodule

// File: rtl/sig_match.sv
module sig_match #(
  parameter int SIGW = 64
) (
  input  logic [SIGW-1:0] wsig,
  input  logic [SIGW-1:0] rsig,
  output logic            hit
);

  // Any shared set bit counts as a conflict, hash collisions included.
  assign hit = |(wsig & rsig);

endmodule

// File: rtl/commit_token_arb.sv
module commit_token_arb
  import commit_tok_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int SIGW  = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE-1:0]      commit_req,
  input  logic [NCORE*SIGW-1:0] wr_sig,
  input  logic [NCORE*SIGW-1:0] rd_sig,
  output logic [NCORE-1:0]      grant,
  output logic                  bcast_valid,
  output logic [SIGW-1:0]       bcast_sig,
  output logic [NCORE-1:0]      abort
);

  localparam int IW = (NCORE > 1) ? $clog2(NCORE) : 1;

  tok_state_e       state_q;
  logic [IW-1:0]    owner_q;
  logic [IW-1:0]    last_q;
  logic [SIGW-1:0]  sig_q;
  logic [NCORE-1:0] abort_q;
  logic [NCORE-1:0] hit;
  logic [NCORE-1:0] own_mask;
  logic [NCORE-1:0] elig;
  logic             pick_any;
  logic [IW-1:0]    pick_idx;

  assign own_mask = NCORE'(1) << owner_q;

  // Eligible requests: all requests when idle; in the evaluation cycle,
  // aborted cores and the current owner are masked out.
  always_comb begin
    case (state_q)
      TOK_IDLE: elig = commit_req;
      TOK_EVAL: elig = commit_req & ~abort_q & ~own_mask;
      default:  elig = '0;
    endcase
  end

  rr_pick #(.N(NCORE), .IW(IW)) u_pick (
    .req  (elig),
    .last (last_q),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  for (genvar g = 0; g < NCORE; g++) begin : g_match
    sig_match #(.SIGW(SIGW)) u_match (
      .wsig (sig_q),
      .rsig (rd_sig[g*SIGW +: SIGW]),
      .hit  (hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TOK_IDLE;
      owner_q <= '0;
      last_q  <= IW'(NCORE - 1);
      sig_q   <= '0;
      abort_q <= '0;
    end else begin
      case (state_q)
        TOK_BCAST: begin
          abort_q <= hit & ~own_mask;
          state_q <= TOK_EVAL;
        end
        default: begin
          abort_q <= '0;
          if (pick_any) begin
            state_q <= TOK_BCAST;
            owner_q <= pick_idx;
            last_q  <= pick_idx;
            sig_q   <= wr_sig[int'(pick_idx)*SIGW +: SIGW];
          end else begin
            state_q <= TOK_IDLE;
          end
        end
      endcase
    end
  end

  assign grant       = (state_q != TOK_IDLE) ? own_mask : '0;
  assign bcast_valid = (state_q == TOK_BCAST);
  assign bcast_sig   = bcast_valid ? sig_q : '0;
  assign abort       = (state_q == TOK_EVAL) ? abort_q : '0;

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> ((grant & $past(commit_req)) != '0));

  assert_two_cycle_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |=> (!bcast_valid && $stable(grant) && (grant != '0)));

  assert_abort_after_bcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (abort != '0) |-> $past(bcast_valid));

  assert_committer_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort & grant) == '0);

  assert_no_grant_to_aborted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort != '0) |=> ((grant & $past(abort)) == '0));

endmodule

// File: tb/commit_token_arb_tb.sv
module commit_token_arb_tb_top;

  localparam int NC = 4;
  localparam int SW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NC-1:0]  req = '0;
  logic [SW-1:0]  ws [NC];
  logic [SW-1:0]  rs [NC];
  logic [NC*SW-1:0] wflat, rflat;
  logic [NC-1:0]  grant, abort;
  logic           bcast_valid;
  logic [SW-1:0]  bcast_sig;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      wflat[i*SW +: SW] = ws[i];
      rflat[i*SW +: SW] = rs[i];
    end
  end

  commit_token_arb #(.NCORE(NC), .SIGW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .commit_req(req), .wr_sig(wflat), .rd_sig(rflat),
    .grant(grant), .bcast_valid(bcast_valid), .bcast_sig(bcast_sig), .abort(abort)
  );

  // Requirement-level model: 0 idle, 1 broadcast, 2 evaluation
  int m_state = 0, m_owner = 0, m_last = NC - 1, prev_state = 0;
  logic [SW-1:0] m_sig = '0;
  logic [NC-1:0] m_abort = '0, prev_abort = '0;

  function automatic int rr(logic [NC-1:0] r, int last);
    for (int k = 1; k <= NC; k++)
      if (r[(last + k) % NC]) return (last + k) % NC;
    return -1;
  endfunction

  always @(posedge clk) begin
    int p;
    logic [NC-1:0] e;
    prev_state = m_state;
    prev_abort = m_abort;
    if (!rst_n) begin
      m_state = 0; m_owner = 0; m_last = NC - 1; m_sig = '0; m_abort = '0;
    end else if (m_state == 1) begin
      for (int i = 0; i < NC; i++)
        m_abort[i] = (i != m_owner) && ((m_sig & rs[i]) != '0);
      m_state = 2;
    end else begin
      e = req;
      if (m_state == 2) e = req & ~m_abort & ~(NC'(1) << m_owner);
      m_abort = '0;
      p = rr(e, m_last);
      if (p >= 0) begin
        m_state = 1; m_owner = p; m_last = p; m_sig = ws[p];
      end else m_state = 0;
    end
  end

  task automatic chk(string tag, logic [SW-1:0] act, logic [SW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string gtag;
    logic [NC-1:0] eg, ea;
    eg = (m_state != 0) ? (NC'(1) << m_owner) : '0;
    ea = (m_state == 2) ? m_abort : '0;
    if (prev_state == 2 && prev_abort != '0) gtag = "R7 grant";
    else if (prev_state == 2) gtag = "R8 grant";
    else gtag = "R2 R3 grant";
    chk(gtag, SW'(grant), SW'(eg));
    chk("R4 bcast_valid", SW'(bcast_valid), SW'(m_state == 1));
    chk("R4 bcast_sig", bcast_sig, (m_state == 1) ? m_sig : '0);
    chk((m_state == 2 && m_owner >= 0) ? "R5 R6 abort" : "R5 abort", SW'(abort), SW'(ea));
  endtask

  task automatic drive(int mode);
    for (int i = 0; i < NC; i++) begin
      if (grant[i]) req[i] = 1'b0;
      else if (abort[i]) req[i] = 1'($urandom % 2);
      else if (!req[i] && ($urandom % 3 == 0)) req[i] = 1'b1;
      case (mode)
        1: begin ws[i] = '0; rs[i] = '0; end
        2: begin ws[i] = '1; rs[i] = '1; end
        default: begin
          ws[i] = SW'($urandom & $urandom);
          rs[i] = SW'($urandom & $urandom & $urandom);
        end
      endcase
    end
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin ws[i] = '0; rs[i] = '0; end
    req = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 grant in reset", SW'(grant), '0);
    chk("R1 abort in reset", SW'(abort), '0);
    chk("R1 bcast in reset", SW'({bcast_valid, bcast_sig != '0}), '0);
    req = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 grant after reset", SW'(grant), '0);
    chk("R1 bcast after reset", SW'(bcast_valid), '0);
    // all request at once: core 0 wins first, then rotation 1,2,3
    req = '1;
    for (int i = 0; i < NC; i++) begin ws[i] = SW'(8'h11 << i); rs[i] = '0; end
    for (int c = 0; c < 2 * NC; c++) begin
      @(negedge clk);
      compare_all();
      if (c % 2 == 0) chk("R3 rotation order", SW'(grant), SW'(NC'(1) << (c / 2)));
      if (grant != '0 && bcast_valid) req = req & ~grant;
    end
    for (int mode = 0; mode < 3; mode++) begin
      for (int c = 0; c < 1500; c++) begin
        @(negedge clk);
        compare_all();
        drive(mode);
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule